// File: doc/BRIEF.md
# Multi-channel DAC command port

This block is the serial register front end of a converter with many output channels. An SPI master sends 24-bit command words. The word is sent most significant bit first and holds a 2-bit mode, a 6-bit address and a 16-bit payload. The mode picks the register bank that a word writes: per-channel output code, per-channel gain, per-channel offset, or a small special-function space.

The special-function space holds four things:
- a control register whose bit 0 powers down every channel;
- one 14-bit offset register per reference group;
- a readback selector;
- a no-operation address.

Reference groups are blocks of consecutive channels. A channel whose group index is past the last reference group is folded onto the last group.

Readback takes two frames. A frame that writes the selector names a register. The value of that register is shifted out on MISO during the next frame.

All SPI lines are sampled by the block clock through two-flop synchronisers. The SPI clock must therefore run well below the block clock. The register contents and the power-down flag are exposed as outputs for the analog section.

Top module: `dac_spi_regs`

## Requirements
- R1: A frame carries the mode in bits 23:22, the address in bits 21:16 and the payload in bits 15:0, sent most significant bit first. Mode 3 writes the payload to the output code of channel n when the address is n+8.
- R2: Mode 1 writes the gain and mode 2 writes the offset of channel n, which is addressed at n+8. After reset, gains read all ones and codes, offsets, group offsets, control and selector read zero.
- R3: With a 14-bit code width, payload bits 1:0 of code, gain and offset writes are dropped. Those registers then appear left-justified in 16 bits with the two low bits zero.
- R4: A mode 0 write to address 1 loads payload bit 0 into the power-down flag, and pwr_down_o follows it.
- R5: A mode 0 write to address 2+g loads payload bits 13:0 into the offset of reference group g. Addresses for g at or above the group count change nothing.
- R6: The group offset of channel n comes from group min(n / CH_PER_GRP, N_GRP-1).
- R7: A frame takes effect only if exactly 24 rising SCLK edges arrived while chip select was low. Frames of 23 or 25 edges change no state.
- R8: Channel writes to an address below 8 or at or above 8+N_CH change no state. So do mode 0 writes to address 0 or to addresses 6 to 63.
- R9: A mode 0 write to address 5 stores payload bits 15:13 as a register kind and bits 12:7 as a register address. The next frame then shifts out 8 zero bits followed by the selected 16-bit value, MSB first. The kinds are: 0 or 1 for output code, 2 for offset, 3 for gain, 4 for special function (address 1 gives the control register, 2+g gives group offset g). Every other kind or address reads zero.
- R10: MISO changes only after a falling SCLK edge or when chip select falls. spi_miso_oe is low while chip select is high and high during a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Drive enable for MISO; low means high impedance |
| chan_code_o | output | N_CH*16 | Output codes, 16 bits per channel, left-justified |
| chan_offs_o | output | N_CH*16 | Per-channel offsets, left-justified |
| chan_gain_o | output | N_CH*16 | Per-channel gains, left-justified |
| chan_gofs_o | output | N_CH*14 | Effective group offset of each channel |
| pwr_down_o | output | 1 | Global power-down flag |

## Verification
Two instances share one SPI bus. One has 16-bit codes and 20 channels in groups of 8. The other has 14-bit codes and 12 channels in groups of 4. In both, the last channels fold onto the last reference group. Every address from 8 to 31 is swept in each of the three channel banks. This shows the address offset, the upper channel bound and the dropped low bits of the 14-bit variant. Frames of 23 and 25 bits, writes to unused and no-operation addresses, and group offset writes with the high payload bits set show that nothing outside the decoded fields leaks into state. The readback sweep covers all eight register kinds against a spread of addresses, so that a wrong mux arm, a wrong field slice or a shifted MISO bit shows up as a mismatch.

// File: rtl/dacspi_pkg.sv
package dacspi_pkg;

    localparam int FRAME_W = 24;
    localparam int WORD_W  = 16;
    localparam int GOFS_W  = 14;
    localparam int CH_BASE = 8;

    typedef enum logic [1:0] {
        MODE_SF   = 2'd0,
        MODE_GAIN = 2'd1,
        MODE_OFFS = 2'd2,
        MODE_DATA = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e               mode;
        logic [5:0]          addr;
        logic [WORD_W-1:0]   data;
    } frame_t;

    typedef struct packed {
        logic [2:0] kind;
        logic [5:0] addr;
    } rb_sel_t;

    localparam logic [5:0] SF_CTRL  = 6'd1;
    localparam logic [5:0] SF_GOFS0 = 6'd2;
    localparam logic [5:0] SF_RBSEL = 6'd5;

    localparam logic [2:0] KIND_CODE_A = 3'd0;
    localparam logic [2:0] KIND_CODE_B = 3'd1;
    localparam logic [2:0] KIND_OFFS   = 3'd2;
    localparam logic [2:0] KIND_GAIN   = 3'd3;
    localparam logic [2:0] KIND_SF     = 3'd4;

    function automatic int grp_of(input int ch, input int cpg, input int ngrp);
        int g;
        g = ch / cpg;
        return (g >= ngrp) ? ngrp - 1 : g;
    endfunction

    function automatic logic chan_match(input logic [5:0] a, input int ch);
        return a == 6'(CH_BASE + ch);
    endfunction

endpackage

// File: rtl/dacspi_frame_rx.sv
module dacspi_frame_rx
    import dacspi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic [WORD_W-1:0] rb_word_i,
    output logic              frm_vld_o,
    output frame_t            frm_o,
    output logic              miso_o,
    output logic              miso_oe_o
);
    localparam int CNT_W = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    logic [1:0] sclk_ff, cs_ff, mosi_ff;
    logic       sclk_d, cs_d;
    logic       sclk_s, cs_s, mosi_s;
    logic       sclk_rise, sclk_fall, cs_rise, cs_fall;

    logic [FRAME_W-1:0] shift_q, frm_q, tx_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_ff <= 2'b00;
            cs_ff   <= 2'b11;
            mosi_ff <= 2'b00;
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
        end else begin
            sclk_ff <= {sclk_ff[0], sclk_i};
            cs_ff   <= {cs_ff[0], cs_n_i};
            mosi_ff <= {mosi_ff[0], mosi_i};
            sclk_d  <= sclk_ff[1];
            cs_d    <= cs_ff[1];
        end
    end

    assign sclk_s    = sclk_ff[1];
    assign cs_s      = cs_ff[1];
    assign mosi_s    = mosi_ff[1];
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_rise   = cs_s & ~cs_d;
    assign cs_fall   = ~cs_s & cs_d;

    // receive shifter and edge counter
    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q   <= '0;
            frm_q     <= '0;
            cnt_q     <= '0;
            frm_vld_o <= 1'b0;
        end else begin
            frm_vld_o <= 1'b0;
            if (cs_s) begin
                cnt_q <= '0;
                if (cs_rise) begin
                    frm_vld_o <= (cnt_q == CNT_FULL);
                    frm_q     <= shift_q;
                end
            end else if (sclk_rise) begin
                shift_q <= {shift_q[FRAME_W-2:0], mosi_s};
                if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign frm_o = frame_t'(frm_q);

    // transmit shifter: loaded at frame start, advanced on falling SCLK
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (cs_fall) begin
            tx_q <= {{(FRAME_W-WORD_W){1'b0}}, rb_word_i};
        end else if (!cs_s && sclk_fall) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign miso_o    = tx_q[FRAME_W-1];
    assign miso_oe_o = ~cs_s;

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_OVER);

    // R10
    miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !cs_fall) |=> $stable(tx_q));

endmodule

// File: rtl/dacspi_reg_file.sv
module dacspi_reg_file
    import dacspi_pkg::*;
#(
    parameter int N_CH       = 16,
    parameter int N_GRP      = 2,
    parameter int CODE_W     = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          frm_vld_i,
    input  frame_t                        frm_i,
    output logic [N_CH-1:0][WORD_W-1:0]   code_o,
    output logic [N_CH-1:0][WORD_W-1:0]   offs_o,
    output logic [N_CH-1:0][WORD_W-1:0]   gain_o,
    output logic [N_GRP-1:0][GOFS_W-1:0]  grp_o,
    output logic                          pd_o,
    output rb_sel_t                       sel_o
);
    localparam int PAD = WORD_W - CODE_W;

    logic [N_CH-1:0][CODE_W-1:0]  code_q, offs_q, gain_q;
    logic [N_GRP-1:0][GOFS_W-1:0] grp_q;
    logic                         pd_q;
    rb_sel_t                      sel_q;
    logic [CODE_W-1:0]            cw_val;

    assign cw_val = frm_i.data[WORD_W-1 -: CODE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            offs_q <= '0;
            gain_q <= '1;
            grp_q  <= '0;
            pd_q   <= 1'b0;
            sel_q  <= '0;
        end else if (frm_vld_i) begin
            case (frm_i.mode)
                MODE_DATA: for (int i = 0; i < N_CH; i++)
                    if (chan_match(frm_i.addr, i)) code_q[i] <= cw_val;
                MODE_OFFS: for (int i = 0; i < N_CH; i++)
                    if (chan_match(frm_i.addr, i)) offs_q[i] <= cw_val;
                MODE_GAIN: for (int i = 0; i < N_CH; i++)
                    if (chan_match(frm_i.addr, i)) gain_q[i] <= cw_val;
                MODE_SF: begin
                    if (frm_i.addr == SF_CTRL) pd_q <= frm_i.data[0];
                    for (int j = 0; j < N_GRP; j++)
                        if (frm_i.addr == 6'(SF_GOFS0 + j))
                            grp_q[j] <= frm_i.data[GOFS_W-1:0];
                    if (frm_i.addr == SF_RBSEL) begin
                        sel_q.kind <= frm_i.data[15:13];
                        sel_q.addr <= frm_i.data[12:7];
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_lj
        assign code_o[i] = WORD_W'(code_q[i]) << PAD;
        assign offs_o[i] = WORD_W'(offs_q[i]) << PAD;
        assign gain_o[i] = WORD_W'(gain_q[i]) << PAD;
    end

    assign grp_o = grp_q;
    assign pd_o  = pd_q;
    assign sel_o = sel_q;

    // R4
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_vld_i |=> $stable(pd_q));

    // R5
    grp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frm_vld_i || frm_i.mode != MODE_SF) |=> $stable(grp_q));

    // R9
    sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frm_vld_i || frm_i.addr != SF_RBSEL) |=> $stable(sel_q));

endmodule

// File: rtl/dacspi_rb_mux.sv
module dacspi_rb_mux
    import dacspi_pkg::*;
#(
    parameter int N_CH  = 16,
    parameter int N_GRP = 2
) (
    input  logic [N_CH-1:0][WORD_W-1:0]  code_i,
    input  logic [N_CH-1:0][WORD_W-1:0]  offs_i,
    input  logic [N_CH-1:0][WORD_W-1:0]  gain_i,
    input  logic [N_GRP-1:0][GOFS_W-1:0] grp_i,
    input  logic                         pd_i,
    input  rb_sel_t                      sel_i,
    output logic [WORD_W-1:0]            word_o
);
    always_comb begin
        word_o = '0;
        case (sel_i.kind)
            KIND_CODE_A, KIND_CODE_B: for (int i = 0; i < N_CH; i++)
                if (chan_match(sel_i.addr, i)) word_o = code_i[i];
            KIND_OFFS: for (int i = 0; i < N_CH; i++)
                if (chan_match(sel_i.addr, i)) word_o = offs_i[i];
            KIND_GAIN: for (int i = 0; i < N_CH; i++)
                if (chan_match(sel_i.addr, i)) word_o = gain_i[i];
            KIND_SF: begin
                if (sel_i.addr == SF_CTRL) word_o = {{(WORD_W-1){1'b0}}, pd_i};
                for (int j = 0; j < N_GRP; j++)
                    if (sel_i.addr == 6'(SF_GOFS0 + j))
                        word_o = WORD_W'(grp_i[j]);
            end
            default: word_o = '0;
        endcase
    end
endmodule

// File: rtl/dac_spi_regs.sv
module dac_spi_regs
    import dacspi_pkg::*;
#(
    parameter int N_CH       = 16,
    parameter int CH_PER_GRP = 8,
    parameter int N_GRP      = 2,
    parameter int CODE_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   spi_sclk,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic                   spi_miso_oe,
    output logic [N_CH*16-1:0]     chan_code_o,
    output logic [N_CH*16-1:0]     chan_offs_o,
    output logic [N_CH*16-1:0]     chan_gain_o,
    output logic [N_CH*14-1:0]     chan_gofs_o,
    output logic                   pwr_down_o
);
    logic                          frm_vld;
    frame_t                        frm;
    logic [WORD_W-1:0]             rb_word;
    logic [N_CH-1:0][WORD_W-1:0]   code_w, offs_w, gain_w;
    logic [N_GRP-1:0][GOFS_W-1:0]  grp_w;
    logic                          pd_w;
    rb_sel_t                       sel_w;

    dacspi_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .sclk_i    (spi_sclk),
        .cs_n_i    (spi_cs_n),
        .mosi_i    (spi_mosi),
        .rb_word_i (rb_word),
        .frm_vld_o (frm_vld),
        .frm_o     (frm),
        .miso_o    (spi_miso),
        .miso_oe_o (spi_miso_oe)
    );

    dacspi_reg_file #(
        .N_CH   (N_CH),
        .N_GRP  (N_GRP),
        .CODE_W (CODE_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .frm_vld_i (frm_vld),
        .frm_i     (frm),
        .code_o    (code_w),
        .offs_o    (offs_w),
        .gain_o    (gain_w),
        .grp_o     (grp_w),
        .pd_o      (pd_w),
        .sel_o     (sel_w)
    );

    dacspi_rb_mux #(
        .N_CH  (N_CH),
        .N_GRP (N_GRP)
    ) u_rb (
        .code_i (code_w),
        .offs_i (offs_w),
        .gain_i (gain_w),
        .grp_i  (grp_w),
        .pd_i   (pd_w),
        .sel_i  (sel_w),
        .word_o (rb_word)
    );

    assign chan_code_o = code_w;
    assign chan_offs_o = offs_w;
    assign chan_gain_o = gain_w;
    assign pwr_down_o  = pd_w;

    for (genvar i = 0; i < N_CH; i++) begin : g_gofs
        localparam int G = grp_of(i, CH_PER_GRP, N_GRP);
        assign chan_gofs_o[i*GOFS_W +: GOFS_W] = grp_w[G];
    end

endmodule

// File: tb/dac_spi_regs_tb_top.sv
`timescale 1ns/1ps
module dac_spi_regs_tb_top;
    localparam int NCH_A = 20, CPG_A = 8;
    localparam int NCH_B = 12, CPG_B = 4;
    localparam int NGRP  = 2;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso_a, oe_a, miso_b, oe_b, pd_a, pd_b;
    logic [NCH_A*16-1:0] code_a, offs_a, gain_a;
    logic [NCH_A*14-1:0] gofs_a;
    logic [NCH_B*16-1:0] code_b, offs_b, gain_b;
    logic [NCH_B*14-1:0] gofs_b;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    logic oe_mid;

    logic [15:0] m_code [0:1][0:31];
    logic [15:0] m_offs [0:1][0:31];
    logic [15:0] m_gain [0:1][0:31];
    logic [13:0] m_grp  [0:1][0:3];
    logic        m_pd   [0:1];
    logic [2:0]  m_kind;
    logic [5:0]  m_addr;

    always #4 clk = ~clk;

    dac_spi_regs #(.N_CH(NCH_A), .CH_PER_GRP(CPG_A), .N_GRP(NGRP), .CODE_W(16)) dut_i (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso_a), .spi_miso_oe(oe_a), .chan_code_o(code_a),
        .chan_offs_o(offs_a), .chan_gain_o(gain_a), .chan_gofs_o(gofs_a),
        .pwr_down_o(pd_a));

    dac_spi_regs #(.N_CH(NCH_B), .CH_PER_GRP(CPG_B), .N_GRP(NGRP), .CODE_W(14)) dut14_i (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso_b), .spi_miso_oe(oe_b), .chan_code_o(code_b),
        .chan_offs_o(offs_b), .chan_gain_o(gain_b), .chan_gofs_o(gofs_b),
        .pwr_down_o(pd_b));

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int d = 0; d < 2; d++) begin
            for (int c = 0; c < 32; c++) begin
                m_code[d][c] = 16'h0;
                m_offs[d][c] = 16'h0;
                m_gain[d][c] = (d == 0) ? 16'hFFFF : 16'hFFFC;
            end
            for (int g = 0; g < 4; g++) m_grp[d][g] = 14'h0;
            m_pd[d] = 1'b0;
        end
        m_kind = 3'd0;
        m_addr = 6'd0;
    endtask

    task automatic model_apply(input logic [23:0] w);
        logic [1:0]  md;
        logic [5:0]  ad;
        logic [15:0] dt;
        md = w[23:22]; ad = w[21:16]; dt = w[15:0];
        for (int d = 0; d < 2; d++) begin
            int nch;
            logic [15:0] msk;
            nch = (d == 0) ? NCH_A : NCH_B;
            msk = (d == 0) ? 16'hFFFF : 16'hFFFC;
            if (md != 2'd0) begin
                if (ad >= 6'd8 && int'(ad) - 8 < nch) begin
                    if (md == 2'd3) m_code[d][ad-8] = dt & msk;
                    if (md == 2'd2) m_offs[d][ad-8] = dt & msk;
                    if (md == 2'd1) m_gain[d][ad-8] = dt & msk;
                end
            end else begin
                if (ad == 6'd1) m_pd[d] = dt[0];
                if (ad >= 6'd2 && int'(ad) < 2 + NGRP) m_grp[d][ad-2] = dt[13:0];
            end
        end
        if (md == 2'd0 && ad == 6'd5) begin
            m_kind = dt[15:13];
            m_addr = dt[12:7];
        end
    endtask

    function automatic logic [15:0] rb_exp(input int d);
        int nch;
        logic hit;
        nch = (d == 0) ? NCH_A : NCH_B;
        hit = (m_addr >= 6'd8) && (int'(m_addr) - 8 < nch);
        case (m_kind)
            3'd0, 3'd1: return hit ? m_code[d][m_addr-8] : 16'h0;
            3'd2:       return hit ? m_offs[d][m_addr-8] : 16'h0;
            3'd3:       return hit ? m_gain[d][m_addr-8] : 16'h0;
            3'd4: begin
                if (m_addr == 6'd1) return {15'h0, m_pd[d]};
                if (m_addr >= 6'd2 && int'(m_addr) < 2 + NGRP) return {2'b00, m_grp[d][m_addr-2]};
                return 16'h0;
            end
            default: return 16'h0;
        endcase
    endfunction

    task automatic xfer(input logic [23:0] w, input int nbits,
                        output logic [23:0] ra, output logic [23:0] rb);
        ra = '0; rb = '0;
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 24) ? w[23-i] : 1'b0;
            wait_clk(HALF);
            if (i < 24) begin
                ra = {ra[22:0], miso_a};
                rb = {rb[22:0], miso_b};
            end
            if (i == 3) oe_mid = oe_a & oe_b;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic send(input logic [23:0] w);
        logic [23:0] ra, rb;
        xfer(w, 24, ra, rb);
        model_apply(w);
    endtask

    task automatic check_state(input string req);
        for (int c = 0; c < NCH_A; c++) begin
            chk(req, "code_a", 32'(code_a[c*16 +: 16]), 32'(m_code[0][c]));
            chk(req, "gain_a", 32'(gain_a[c*16 +: 16]), 32'(m_gain[0][c]));
            chk(req, "offs_a", 32'(offs_a[c*16 +: 16]), 32'(m_offs[0][c]));
            chk(req, "gofs_a", 32'(gofs_a[c*14 +: 14]),
                32'(m_grp[0][(c / CPG_A >= NGRP) ? NGRP-1 : c / CPG_A]));
        end
        for (int c = 0; c < NCH_B; c++) begin
            chk(req, "code_b", 32'(code_b[c*16 +: 16]), 32'(m_code[1][c]));
            chk(req, "gain_b", 32'(gain_b[c*16 +: 16]), 32'(m_gain[1][c]));
            chk(req, "offs_b", 32'(offs_b[c*16 +: 16]), 32'(m_offs[1][c]));
            chk(req, "gofs_b", 32'(gofs_b[c*14 +: 14]),
                32'(m_grp[1][(c / CPG_B >= NGRP) ? NGRP-1 : c / CPG_B]));
        end
        chk(req, "pd_a", 32'(pd_a), 32'(m_pd[0]));
        chk(req, "pd_b", 32'(pd_b), 32'(m_pd[1]));
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] ra, rb;
        model_reset();
        wait_clk(10);
        rst = 1'b0;
        wait_clk(5);

        // R2: reset values; R10: output enable idle
        check_state("R2");
        chk("R10", "oe idle", 32'(oe_a | oe_b), 32'h0);

        // R1 R3: code sweep over addresses 8..31
        for (int c = 0; c < 24; c++)
            send({2'b11, 6'(c + 8), 16'(16'(c) * 16'h0B3D ^ 16'h5A5B)});
        check_state("R1 R3");
        chk("R10", "oe in frame", 32'(oe_mid), 32'h1);
        chk("R10", "oe after frame", 32'(oe_a | oe_b), 32'h0);

        // R2 R3: gain and offset sweeps
        for (int c = 0; c < 24; c++)
            send({2'b01, 6'(c + 8), 16'(16'(c) * 16'h1F07 + 16'h0123)});
        for (int c = 0; c < 24; c++)
            send({2'b10, 6'(c + 8), 16'(16'(c) * 16'h3313 ^ 16'hC3C3)});
        check_state("R2 R3");

        // R5 R6: group offsets with high payload bits set; address 4 is out of range
        send({2'b00, 6'd2, 16'hC000 | 16'h1234});
        send({2'b00, 6'd3, 16'h8000 | 16'h2ACE});
        send({2'b00, 6'd4, 16'h3FFF});
        check_state("R5 R6");

        // R4: power-down set then cleared
        send({2'b00, 6'd1, 16'h0001});
        chk("R4", "pd set a", 32'(pd_a), 32'h1);
        chk("R4", "pd set b", 32'(pd_b), 32'h1);
        send({2'b00, 6'd1, 16'hFFFE});
        chk("R4", "pd clear", 32'(pd_a | pd_b), 32'h0);

        // R7: short and long frames are dropped
        xfer({2'b11, 6'd8, 16'hBEEF}, 23, ra, rb);
        xfer({2'b11, 6'd9, 16'hBEEF}, 25, ra, rb);
        xfer({2'b00, 6'd1, 16'h0001}, 25, ra, rb);
        check_state("R7");

        // R8: unused and no-operation addresses
        send({2'b11, 6'd7, 16'hAAAA});
        send({2'b01, 6'd63, 16'h5555});
        send({2'b10, 6'd0, 16'h1111});
        send({2'b00, 6'd0, 16'hFFFF});
        send({2'b00, 6'd6, 16'hFFFF});
        send({2'b00, 6'd7, 16'hFFFF});
        check_state("R8");

        // R9: readback sweep over all kinds
        send({2'b00, 6'd1, 16'h0001});
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 9; s++) begin
                logic [5:0] a;
                case (s)
                    0: a = 6'd0;  1: a = 6'd1;  2: a = 6'd2;
                    3: a = 6'd3;  4: a = 6'd8;  5: a = 6'd13;
                    6: a = 6'd19; 7: a = 6'd27; default: a = 6'd63;
                endcase
                send({2'b00, 6'd5, k[2:0], a, 7'h55});
                xfer(24'h0, 24, ra, rb);
                chk("R9", $sformatf("rb_a k%0d a%0d", k, a), 32'(ra), {16'h0, rb_exp(0)});
                chk("R9", $sformatf("rb_b k%0d a%0d", k, a), 32'(rb), {16'h0, rb_exp(1)});
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule